// File: doc/BRIEF.md
# Multiplexed Address/Data Burst Bus Master

This block is a bus master for a shared 32-bit bus that carries both address and data on the same lines. A requester gives it a 26-bit address, a 3-bit access-size code and a direction flag. The master then runs one framed transaction. The first cycle is an address-information cycle. Data cycles follow, one for each beat. The bus sees four controls: a frame strobe, a chip select, a one-cycle start strobe and a read-not-write line.

A static configuration input picks the wait mode. In lead-wait mode the master inserts one internal wait cycle between the address cycle and the first data beat. The later beats get no internal wait. In the other mode there is no internal wait at all. In both modes, each data cycle can be stretched by the slave through a ready input.

For reads, every beat is returned to the requester with a valid strobe and a beat index. Every transaction ends with a done pulse. After the frame is released, one idle gap cycle passes before the master accepts a new request.

Top module: `mpx_burst_master`

## Requirements
- R1: In the address cycle the master drives the bus with the size code on bits 31:29, zeros on bits 28:26 and the address on bits 25:0. In that cycle `bus_ad_oe`=1, `bus_start`=1, `bus_frame`=1 and `bus_cs`=1. `bus_start` is high for that single cycle only.
- R2: The number of data beats depends on the size code. Codes 000 (byte), 001 (2 bytes) and 010 (4 bytes) take one beat. Code 011 (8 bytes) takes two beats. Any code with bit 2 set (1xx, a 32-byte burst) takes eight beats.
- R3: When `cfg_lead_wait`=1, the master holds exactly one wait cycle after the address cycle. In that cycle `bus_ad_oe`=0, no beat is taken and `bus_rdy` is ignored. The beats after the first get no internal wait.
- R4: When `cfg_lead_wait`=0, the data phase starts in the cycle right after the address cycle. A beat completes only on a rising edge where `bus_rdy`=1. Each cycle with `bus_rdy`=0 extends the current beat, and the beat counter does not advance.
- R5: On a read, the cycle after each completed beat shows `rd_valid`=1. In that cycle `rd_data` equals the bus value sampled at the completing edge, and `rd_beat` gives the beat index. Indices run 0, 1, 2, … in order.
- R6: `bus_frame` and `bus_cs` stay high from the address cycle through the last data cycle. Both go low in the cycle after the last beat completes.
- R7: `bus_rnw` equals the inverse of the request's write flag throughout the frame, and it stays constant while the frame is high.
- R8: `req_ready` is low while the frame is high and also during the one idle gap cycle after it. It returns high in the cycle after the gap.
- R9: `done` pulses for one cycle, in the cycle right after the last beat completes. This applies to reads and to writes.
- R10: On a write, every data cycle drives `req_wdata` onto the bus with `bus_ad_oe`=1, and `wr_beat` gives the current beat index. On a read, the data cycles leave `bus_ad_oe`=0.
- R11: An active-low asynchronous reset abandons any transaction. During reset the frame, chip select and start outputs go low and `req_ready` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lead_wait | input | 1 | 1: one internal wait before the first beat |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request accepted this edge |
| req_addr | input | 26 | Transfer address |
| req_size | input | 3 | Access-size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data for beat `wr_beat` |
| wr_beat | output | 3 | Index of the beat being written |
| rd_valid | output | 1 | Read beat returned |
| rd_data | output | 32 | Returned read beat |
| rd_beat | output | 3 | Index of the returned beat |
| done | output | 1 | Transaction complete pulse |
| bus_ad_out | output | 32 | Multiplexed address/data, driven value |
| bus_ad_oe | output | 1 | Output enable for the multiplexed lines |
| bus_ad_in | input | 32 | Multiplexed lines, sampled value |
| bus_frame | output | 1 | Frame strobe, active high |
| bus_cs | output | 1 | Chip select, active high |
| bus_start | output | 1 | Start-of-access strobe, active high |
| bus_rnw | output | 1 | 1 = read, 0 = write |
| bus_rdy | input | 1 | Slave ready |

## Verification
The hardest case is an eight-beat burst in which ready is withheld at random and independently on each beat. The test must also combine this with the lead-wait cycle, where a high ready has to be ignored. The bench acts as the slave. Each vector carries a stall probability, and the bench draws ready afresh on every data cycle. It drives ready high on purpose during the address cycle and the lead-wait cycle, and it tracks beat completion from its own record of the ready values it applied.

// File: rtl/mpx_pkg.sv
package mpx_pkg;
  localparam int AD_W   = 32;
  localparam int ADDR_W = 26;
  localparam int SIZE_W = 3;
  localparam int BEAT_W = 3;
  localparam int NB_W   = BEAT_W + 1;
  localparam int PAD_W  = AD_W - SIZE_W - ADDR_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_LWAIT, ST_DATA, ST_GAP
  } mpx_state_e;

  // number of data beats for an access-size code
  function automatic logic [NB_W-1:0] beats_for(input logic [SIZE_W-1:0] sz);
    logic [NB_W-1:0] n;
    if (sz[SIZE_W-1])      n = NB_W'(8);
    else if (sz == 3'b011) n = NB_W'(2);
    else                   n = NB_W'(1);
    return n;
  endfunction

  // address-information word placed on the bus in the first cycle
  function automatic logic [AD_W-1:0] addr_word(input logic [SIZE_W-1:0] sz,
                                                input logic [ADDR_W-1:0] a);
    return {sz, {PAD_W{1'b0}}, a};
  endfunction
endpackage

// File: rtl/mpx_seq.sv
module mpx_seq
  import mpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_write,
  input  logic              cfg_lead_wait,
  input  logic              bus_rdy,
  output mpx_state_e        state,
  output logic [BEAT_W-1:0] beat_cnt,
  output logic              take_beat,
  output logic              last_beat,
  output logic              accept,
  output logic              write_q,
  output logic              done_o
);
  logic [NB_W-1:0] nbeats_q;
  logic            lead_q;

  assign accept    = req_valid && (state == ST_IDLE);
  assign take_beat = (state == ST_DATA) && bus_rdy;
  assign last_beat = ({1'b0, beat_cnt} == (nbeats_q - NB_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      beat_cnt <= '0;
      nbeats_q <= NB_W'(1);
      lead_q   <= 1'b0;
      write_q  <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= take_beat && last_beat;
      unique case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_ADDR;
          beat_cnt <= '0;
          nbeats_q <= beats_for(req_size);
          lead_q   <= cfg_lead_wait;
          write_q  <= req_write;
        end
        ST_ADDR:  state <= lead_q ? ST_LWAIT : ST_DATA;
        ST_LWAIT: state <= ST_DATA;
        ST_DATA: if (bus_rdy) begin
          if (last_beat) state <= ST_GAP;
          else           beat_cnt <= beat_cnt + BEAT_W'(1);
        end
        ST_GAP:   state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R2
  beat_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_beat |-> ({1'b0, beat_cnt} < nbeats_q));
  // R3
  lead_wait_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LWAIT) |=> (state == ST_DATA));
  // R4
  no_lead_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && !lead_q) |=> (state == ST_DATA));
  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(take_beat));
endmodule

// File: rtl/mpx_addr_enc.sv
module mpx_addr_enc
  import mpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SIZE_W-1:0] size,
  input  logic [ADDR_W-1:0] addr,
  output logic [AD_W-1:0]   word_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= addr_word(size, addr);
  end

  // R1
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> (word_q[AD_W-SIZE_W-1:ADDR_W] == '0));
endmodule

// File: rtl/mpx_rd_capture.sv
module mpx_rd_capture
  import mpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [AD_W-1:0]   bus_in,
  input  logic [BEAT_W-1:0] beat,
  output logic              valid_q,
  output logic [AD_W-1:0]   data_q,
  output logic [BEAT_W-1:0] beat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      beat_q  <= '0;
    end else begin
      valid_q <= take;
      if (take) begin
        data_q <= bus_in;
        beat_q <= beat;
      end
    end
  end

  // R5
  valid_from_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(take));
  // R5
  beat_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && $past(valid_q) && beat_q != '0) |-> (beat_q == $past(beat_q) + BEAT_W'(1)));
endmodule

// File: rtl/mpx_burst_master.sv
module mpx_burst_master
  import mpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_lead_wait,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_write,
  input  logic [AD_W-1:0]   req_wdata,
  output logic [BEAT_W-1:0] wr_beat,
  output logic              rd_valid,
  output logic [AD_W-1:0]   rd_data,
  output logic [BEAT_W-1:0] rd_beat,
  output logic              done,
  output logic [AD_W-1:0]   bus_ad_out,
  output logic              bus_ad_oe,
  input  logic [AD_W-1:0]   bus_ad_in,
  output logic              bus_frame,
  output logic              bus_cs,
  output logic              bus_start,
  output logic              bus_rnw,
  input  logic              bus_rdy
);
  mpx_state_e        state;
  logic [BEAT_W-1:0] beat_cnt;
  logic              take_beat, last_beat, accept, write_q;
  logic [AD_W-1:0]   addr_word_q;
  logic              in_addr, in_data, rd_take;

  mpx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
    .req_write(req_write), .cfg_lead_wait(cfg_lead_wait), .bus_rdy(bus_rdy),
    .state(state), .beat_cnt(beat_cnt), .take_beat(take_beat),
    .last_beat(last_beat), .accept(accept), .write_q(write_q), .done_o(done)
  );

  mpx_addr_enc u_enc (
    .clk(clk), .rst_n(rst_n), .load(accept), .size(req_size),
    .addr(req_addr), .word_q(addr_word_q)
  );

  assign rd_take = take_beat && !write_q;

  mpx_rd_capture u_cap (
    .clk(clk), .rst_n(rst_n), .take(rd_take), .bus_in(bus_ad_in),
    .beat(beat_cnt), .valid_q(rd_valid), .data_q(rd_data), .beat_q(rd_beat)
  );

  assign in_addr   = (state == ST_ADDR);
  assign in_data   = (state == ST_DATA);
  assign req_ready = (state == ST_IDLE);
  assign bus_frame = in_addr || in_data || (state == ST_LWAIT);
  assign bus_cs    = bus_frame;
  assign bus_start = in_addr;
  assign bus_rnw   = bus_frame ? !write_q : 1'b1;
  assign bus_ad_oe = in_addr || (in_data && write_q);
  assign wr_beat   = beat_cnt;
  assign bus_ad_out = in_addr ? addr_word_q :
                      (in_data && write_q) ? req_wdata : '0;

  // R1
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !bus_start);
  // R7
  rnw_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_frame && $past(bus_frame)) |-> $stable(bus_rnw));
  // R8
  gap_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_frame) |-> !req_ready);
  // R6
  done_frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_frame);
endmodule

// File: tb/tb_mpx_burst_master.sv
module tb_mpx_burst_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_lead_wait = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [25:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [2:0]  wr_beat;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [2:0]  rd_beat;
  logic        done;
  logic [31:0] bus_ad_out;
  logic        bus_ad_oe;
  logic [31:0] bus_ad_in = '0;
  logic        bus_frame, bus_cs, bus_start, bus_rnw;
  logic        bus_rdy = 1'b0;

  int nvec = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mpx_burst_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_lead_wait(cfg_lead_wait),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .wr_beat(wr_beat), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_beat(rd_beat), .done(done), .bus_ad_out(bus_ad_out),
    .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in), .bus_frame(bus_frame),
    .bus_cs(bus_cs), .bus_start(bus_start), .bus_rnw(bus_rnw), .bus_rdy(bus_rdy)
  );

  // vector: {write, lead, size[2:0], stall[3:0], addr[25:0]}
  localparam int NV = 10;
  localparam logic [34:0] VEC [0:NV-1] = '{
    {1'b0, 1'b0, 3'b000, 4'd0,  26'h0000123},
    {1'b0, 1'b1, 3'b001, 4'd6,  26'h1ABCDE0},
    {1'b0, 1'b0, 3'b010, 4'd9,  26'h3FFFFFF},
    {1'b0, 1'b1, 3'b011, 4'd4,  26'h0200008},
    {1'b0, 1'b0, 3'b100, 4'd0,  26'h0000040},
    {1'b0, 1'b1, 3'b111, 4'd8,  26'h2345660},
    {1'b0, 1'b0, 3'b101, 4'd11, 26'h1111100},
    {1'b1, 1'b0, 3'b011, 4'd5,  26'h0C0FFE8},
    {1'b1, 1'b1, 3'b110, 4'd7,  26'h0ABCD00},
    {1'b1, 1'b0, 3'b000, 4'd0,  26'h3000001}
  };

  function automatic int n_beats(input logic [2:0] s);
    if (s >= 3'd4) return 8;
    if (s == 3'd3) return 2;
    return 1;
  endfunction

  function automatic logic [31:0] rpat(input logic [25:0] a, input int b);
    return {3'b101, a, b[2:0]} ^ 32'h5A3C_0000;
  endfunction

  function automatic logic [31:0] wpat(input logic [25:0] a, input int b);
    return ~rpat(a, b) + 32'(b);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [34:0] v);
    logic wr, ld;
    logic [2:0] sz;
    logic [3:0] stall;
    logic [25:0] ad;
    int nb, beat;
    logic rdy_now;
    {wr, ld, sz, stall, ad} = v;
    nb = n_beats(sz);
    beat = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 idle ready", 32'(req_ready), 32'd1);
    cfg_lead_wait = ld; req_valid = 1'b1; req_addr = ad;
    req_size = sz; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    // address cycle
    chk(bus_ad_out == {sz, 3'b000, ad}, "R1 address word", bus_ad_out, {sz, 3'b000, ad});
    chk(bus_start && bus_frame && bus_cs && bus_ad_oe, "R1 address strobes",
        {28'd0, bus_start, bus_frame, bus_cs, bus_ad_oe}, 32'hF);
    chk(bus_rnw == !wr, "R7 rnw", 32'(bus_rnw), 32'(!wr));
    chk(req_ready == 1'b0, "R8 busy", 32'(req_ready), 32'd0);
    bus_rdy = 1'b1;                // ignored in the address cycle
    @(negedge clk);
    if (ld) begin
      chk(bus_frame && !bus_start && !bus_ad_oe && !rd_valid, "R3 lead wait",
          {28'd0, bus_frame, bus_start, bus_ad_oe, rd_valid}, 32'h8);
      bus_rdy = 1'b1;              // must be ignored
      @(negedge clk);
      chk(!rd_valid && !done && bus_frame, "R3 ready ignored",
          {29'd0, rd_valid, done, bus_frame}, 32'h1);
    end else begin
      chk(!rd_valid && bus_frame, "R4 data follows address",
          {30'd0, rd_valid, bus_frame}, 32'h1);
    end
    while (beat < nb) begin
      // in a data cycle
      chk(bus_frame && bus_cs && !bus_start, "R6 frame in data",
          {29'd0, bus_frame, bus_cs, bus_start}, 32'h6);
      chk(bus_rnw == !wr, "R7 rnw held", 32'(bus_rnw), 32'(!wr));
      if (wr) begin
        req_wdata = wpat(ad, beat);
        #1;
        chk(bus_ad_oe && bus_ad_out == wpat(ad, beat), "R10 write data",
            bus_ad_out, wpat(ad, beat));
        chk(wr_beat == 3'(beat), "R10 write index", 32'(wr_beat), 32'(beat));
      end else begin
        chk(!bus_ad_oe, "R10 read oe low", 32'(bus_ad_oe), 32'd0);
      end
      rdy_now = (4'($urandom_range(0, 15)) >= stall);
      bus_rdy = rdy_now;
      bus_ad_in = rpat(ad, beat);
      @(negedge clk);
      if (rdy_now) begin
        if (!wr) begin
          chk(rd_valid && rd_data == rpat(ad, beat), "R5 read data",
              rd_data, rpat(ad, beat));
          chk(rd_beat == 3'(beat), "R5 beat order", 32'(rd_beat), 32'(beat));
        end
        beat++;
        if (beat == nb) begin
          chk(done == 1'b1, "R9 done", 32'(done), 32'd1);
          chk(!bus_frame && !bus_cs, "R6 frame release",
              {30'd0, bus_frame, bus_cs}, 32'd0);
          chk(req_ready == 1'b0, "R8 gap", 32'(req_ready), 32'd0);
          chk(beat == n_beats(sz), "R2 beat count", 32'(beat), 32'(n_beats(sz)));
        end else begin
          chk(done == 1'b0, "R9 no early done", 32'(done), 32'd0);
        end
      end else begin
        chk(!rd_valid && !done, "R4 stall holds", {30'd0, rd_valid, done}, 32'd0);
      end
    end
    bus_rdy = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && !done, "R8 ready after gap",
        {30'd0, req_ready, done}, 32'h2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_frame && !bus_cs && !bus_start && req_ready && !rd_valid && !done,
        "R11 reset state",
        {26'd0, bus_frame, bus_cs, bus_start, req_ready, rd_valid, done}, 32'h4);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_txn(VEC[i]);
    // repeat full bursts with heavy stall in both modes
    for (int i = 0; i < 4; i++)
      run_txn({1'b0, i[0], 3'b100, 4'd12, 26'(26'h0100000 + i * 32)});
    // reset in the middle of a burst
    @(negedge clk);
    cfg_lead_wait = 1'b0; req_valid = 1'b1; req_addr = 26'h0000200;
    req_size = 3'b100; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; bus_rdy = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!bus_frame && !bus_cs && !bus_start && req_ready, "R11 reset abandons",
        {28'd0, bus_frame, bus_cs, bus_start, req_ready}, 32'h1);
    bus_rdy = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run_txn({1'b0, 1'b1, 3'b010, 4'd3, 26'h0000ABC});
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule